// File: doc/BRIEF.md
# Regulator Fault and Hiccup Sequencer

This block is the digital supervisor of a multi-phase buck controller. The analog front end supplies comparator flags, and the block turns them into a per-phase output mode, soft-start ramp commands and a power-good signal. The flags cover supply and enable status, overcurrent on each channel, overvoltage, the power-good threshold, the reference moving, and three ramp levels. The analog front end, the ramp generator and the modulator sit outside the block.

When supply and enable are both valid, the block samples which phases are fitted. A phase counts as fitted when its strobe reports the pin pulled below the supply. The block then starts a soft-start and watches for faults. On an overcurrent it runs a hiccup sequence: all switches off, discharge of the ramp, then a restart. The third overcurrent locks the converter off. An overvoltage latches the enabled phases low. Only a full power-on reset clears either latch.

Top module: `vr_fault_seq`

## Requirements
- R1: The block leaves its off state only while both `por_ok` and `en_ok` are high. In the off state, and whenever either input drops, every phase reads 2'b10. `ss_charge`, `ss_discharge`, `ss_clamp` and `pgood` are low, and both the fault latches and the overcurrent count are cleared.
- R2: Phase strobes are captured once, at power-up. Phase i is enabled only if `phase_pulled_low[i]` is 1. Phase i drives `pwm_mode[2i+1:2i]`, encoded as 2'b00 forced low, 2'b01 normal, 2'b10 high impedance. A disabled phase reads 2'b10 in every state.
- R3: During soft-start, `ss_charge` and `ss_clamp` are high and enabled phases read 2'b01. Once `ss_top` is seen, `ss_clamp` drops and the converter runs with `ss_charge` still high.
- R4: An overcurrent counts as an event only when an enabled phase's flag is seen high on two consecutive synchronized samples. A one-cycle pulse has no effect.
- R5: An overcurrent event sets every phase to 2'b10 and drops `ss_charge`. `ss_discharge` rises only once `ss_below90` is seen. When `ss_below_lo` is then seen, discharge stops and a new soft-start begins.
- R6: The event count saturates at the retry limit (default 3). The third event locks every phase at 2'b10 with neither ramp command active, and ramp flags are then ignored. Only a power-on reset releases the lockout and clears the count.
- R7: `ss_charge` and `ss_discharge` are never high together.
- R8: An overvoltage during soft-start, run, hiccup or lockout sets enabled phases to 2'b00 and drops the ramp commands. It takes priority over overcurrent and stays latched after `ov_flag` falls, until a power-on reset.
- R9: `pgood` rises in the run state when `pg_above` is seen. It falls when `pg_above` is seen low while `ref_moving` is low. While `ref_moving` is high, a low `pg_above` is ignored.
- R10: `pgood` is forced low by power loss, by overvoltage and by any exit from the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above its power-on threshold |
| en_ok | input | 1 | Enable input above its threshold |
| phase_pulled_low | input | NPHASE | Per-phase strobe: pin pulled below the supply, so the phase is fitted |
| oc_flag | input | NPHASE | Per-channel overcurrent comparator |
| ov_flag | input | 1 | Output above the overvoltage trip level |
| pg_above | input | 1 | Output above the power-good threshold |
| ref_moving | input | 1 | Reference is changing |
| ss_top | input | 1 | Ramp has reached its final level |
| ss_below90 | input | 1 | Ramp below 90% of the supply |
| ss_below_lo | input | 1 | Ramp below the restart level |
| pwm_mode | output | 2*NPHASE | Per-phase output mode, two bits per phase |
| ss_charge | output | 1 | Charge the soft-start node |
| ss_discharge | output | 1 | Discharge the soft-start node |
| ss_clamp | output | 1 | Pulse widths clamped by the rising ramp |
| pgood | output | 1 | Power good, active high |

## Verification
Each flag passes through SYNC_STAGES flops, two by default, before the state register sees it. A level or ramp flag therefore changes the outputs on the third rising edge after it settles. An overcurrent needs one more edge for its second sample, so it acts on the fourth. `pgood` follows `pg_above` with the same three-edge delay. The bench changes inputs just after a falling edge and waits five edges before it samples, which covers every path. The one-cycle overcurrent pulse and the lockout are checked at the same distance, to confirm that nothing moved.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;
   typedef enum logic [1:0] {
      PWM_LOW  = 2'b00,
      PWM_NORM = 2'b01,
      PWM_HIZ  = 2'b10
   } pwm_mode_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_DETECT,
      ST_SOFT,
      ST_RUN,
      ST_HIC_WAIT,
      ST_HIC_DIS,
      ST_LOCK,
      ST_OVP
   } seq_state_e;
endpackage

// File: rtl/vr_sync.sv
module vr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("vr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vr_oc_filter.sv
module vr_oc_filter #(
   parameter int NPHASE = 3,
   parameter int CONSEC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPHASE-1:0] oc_s,
   output logic [NPHASE-1:0] oc_evt
);
   if (CONSEC < 1) begin : g_bad_consec
      $error("vr_oc_filter: CONSEC must be at least 1");
   end

   for (genvar i = 0; i < NPHASE; i++) begin : g_ph
      if (CONSEC == 1) begin : g_direct
         assign oc_evt[i] = oc_s[i];
      end else begin : g_window
         localparam int WINW = CONSEC - 1;
         logic [WINW-1:0] win;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win <= '0;
            else        win <= WINW'({win, oc_s[i]});
         end
         assign oc_evt[i] = oc_s[i] & (&win);
      end
   end
endmodule

// File: rtl/vr_pwm_map.sv
module vr_pwm_map
   import vr_seq_pkg::*;
#(
   parameter int NPHASE = 3
) (
   input  pwm_mode_e             common_mode,
   input  logic [NPHASE-1:0]     phase_en,
   output logic [2*NPHASE-1:0]   pwm_mode
);
   for (genvar i = 0; i < NPHASE; i++) begin : g_ph
      assign pwm_mode[2*i +: 2] = phase_en[i] ? common_mode : PWM_HIZ;
   end
endmodule

// File: rtl/vr_fault_seq.sv
module vr_fault_seq
   import vr_seq_pkg::*;
#(
   parameter int NPHASE      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int OC_CONSEC   = 2,
   parameter int RETRY_LIMIT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  por_ok,
   input  logic                  en_ok,
   input  logic [NPHASE-1:0]     phase_pulled_low,
   input  logic [NPHASE-1:0]     oc_flag,
   input  logic                  ov_flag,
   input  logic                  pg_above,
   input  logic                  ref_moving,
   input  logic                  ss_top,
   input  logic                  ss_below90,
   input  logic                  ss_below_lo,
   output logic [2*NPHASE-1:0]   pwm_mode,
   output logic                  ss_charge,
   output logic                  ss_discharge,
   output logic                  ss_clamp,
   output logic                  pgood
);
   localparam int CNT_W  = $clog2(RETRY_LIMIT + 1);
   localparam int NLEVEL = 8;
   localparam int NFLAG  = NLEVEL + 2 * NPHASE;

   if (NPHASE < 1 || NPHASE > 16) begin : g_bad_nphase
      $error("vr_fault_seq: NPHASE out of range");
   end
   if (RETRY_LIMIT < 1) begin : g_bad_retry
      $error("vr_fault_seq: RETRY_LIMIT must be at least 1");
   end

   // synchronized flags
   logic [NFLAG-1:0]  flags_raw, flags_s;
   logic              por_s, en_s, ov_s, pg_s, ref_s, top_s, b90_s, blo_s;
   logic [NPHASE-1:0] oc_s, pres_s, oc_evt;
   logic              pwr_ok_s;

   assign flags_raw = {phase_pulled_low, oc_flag, por_ok, en_ok, ov_flag,
                       pg_above, ref_moving, ss_top, ss_below90, ss_below_lo};

   vr_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flags_raw),
      .q     (flags_s)
   );

   assign {pres_s, oc_s, por_s, en_s, ov_s, pg_s, ref_s, top_s, b90_s, blo_s} = flags_s;
   assign pwr_ok_s = por_s & en_s;

   vr_oc_filter #(.NPHASE(NPHASE), .CONSEC(OC_CONSEC)) u_ocf (
      .clk    (clk),
      .rst_n  (rst_n),
      .oc_s   (oc_s),
      .oc_evt (oc_evt)
   );

   // sequencer state
   seq_state_e        state_q, state_d;
   logic [CNT_W-1:0]  oc_cnt_q, oc_cnt_d;
   logic [NPHASE-1:0] phase_en_q, phase_en_d;
   logic              pgood_q, pgood_d;
   logic              oc_hit;

   assign oc_hit = |(oc_evt & phase_en_q);

   always_comb begin
      state_d    = state_q;
      oc_cnt_d   = oc_cnt_q;
      phase_en_d = phase_en_q;
      if (!pwr_ok_s) begin
         state_d    = ST_OFF;
         oc_cnt_d   = '0;
         phase_en_d = '0;
      end else if (state_q == ST_OFF) begin
         state_d = ST_DETECT;
      end else if (state_q == ST_DETECT) begin
         phase_en_d = pres_s;
         state_d    = ST_SOFT;
      end else if (ov_s || state_q == ST_OVP) begin
         state_d = ST_OVP;
      end else begin
         case (state_q)
            ST_SOFT, ST_RUN: begin
               if (oc_hit) begin
                  if (oc_cnt_q >= CNT_W'(RETRY_LIMIT - 1)) begin
                     oc_cnt_d = CNT_W'(RETRY_LIMIT);
                     state_d  = ST_LOCK;
                  end else begin
                     oc_cnt_d = oc_cnt_q + 1'b1;
                     state_d  = ST_HIC_WAIT;
                  end
               end else if (state_q == ST_SOFT && top_s) begin
                  state_d = ST_RUN;
               end
            end
            ST_HIC_WAIT: if (b90_s) state_d = ST_HIC_DIS;
            ST_HIC_DIS:  if (blo_s) state_d = ST_SOFT;
            default:     state_d = state_q;
         endcase
      end
   end

   always_comb begin
      pgood_d = pgood_q;
      if (state_d != ST_RUN || state_q != ST_RUN) pgood_d = 1'b0;
      else if (pg_s)                              pgood_d = 1'b1;
      else if (!ref_s)                            pgood_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_OFF;
         oc_cnt_q   <= '0;
         phase_en_q <= '0;
         pgood_q    <= 1'b0;
      end else begin
         state_q    <= state_d;
         oc_cnt_q   <= oc_cnt_d;
         phase_en_q <= phase_en_d;
         pgood_q    <= pgood_d;
      end
   end

   // output decode
   pwm_mode_e common_mode;

   always_comb begin
      case (state_q)
         ST_SOFT, ST_RUN: common_mode = PWM_NORM;
         ST_OVP:          common_mode = PWM_LOW;
         default:         common_mode = PWM_HIZ;
      endcase
   end

   vr_pwm_map #(.NPHASE(NPHASE)) u_map (
      .common_mode (common_mode),
      .phase_en    (phase_en_q),
      .pwm_mode    (pwm_mode)
   );

   assign ss_charge    = (state_q == ST_SOFT) || (state_q == ST_RUN);
   assign ss_discharge = (state_q == ST_HIC_DIS);
   assign ss_clamp     = (state_q == ST_SOFT);
   assign pgood        = pgood_q;
endmodule

// File: rtl/vr_fault_seq_chk.sv
module vr_fault_seq_chk
   import vr_seq_pkg::*;
#(
   parameter int NPHASE = 3,
   parameter int CNT_W  = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                por_ok,
   input logic [2*NPHASE-1:0] pwm_mode,
   input logic                ss_charge,
   input logic                ss_discharge,
   input logic                ss_clamp,
   input logic                pgood,
   input seq_state_e          state_q,
   input logic [NPHASE-1:0]   phase_en_q,
   input logic [CNT_W-1:0]    oc_cnt_q,
   input logic                pwr_ok_s
);
   // R1: supply lost for three samples means everything is off
   assert_power_loss_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_ok && !$past(por_ok) && !$past(por_ok, 2)) |=>
      (!ss_charge && !ss_discharge && !pgood && $countones(pwm_mode) == NPHASE));

   // R2: an unfitted phase never leaves high impedance
   for (genvar i = 0; i < NPHASE; i++) begin : g_unused
      assert_unused_phase_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !phase_en_q[i] |-> pwm_mode[2*i +: 2] == PWM_HIZ);
   end

   // R7: ramp commands are exclusive
   assert_ramp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ss_charge && ss_discharge));

   // R6: event count only falls through the off state
   assert_count_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_cnt_q < $past(oc_cnt_q)) |-> state_q == ST_OFF);

   // R6: lockout holds while power stays good
   assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK && pwr_ok_s) |=> (state_q == ST_LOCK || state_q == ST_OVP));

   // R8: overvoltage latch holds while power stays good
   assert_ovp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OVP && pwr_ok_s) |=> state_q == ST_OVP);

   // R10: power good only while running unclamped
   assert_pgood_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (ss_charge && !ss_clamp && !ss_discharge));
endmodule

bind vr_fault_seq vr_fault_seq_chk #(.NPHASE(NPHASE), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .por_ok       (por_ok),
   .pwm_mode     (pwm_mode),
   .ss_charge    (ss_charge),
   .ss_discharge (ss_discharge),
   .ss_clamp     (ss_clamp),
   .pgood        (pgood),
   .state_q      (state_q),
   .phase_en_q   (phase_en_q),
   .oc_cnt_q     (oc_cnt_q),
   .pwr_ok_s     (pwr_ok_s)
);

// File: tb/vr_fault_seq_test.sv
module vr_fault_seq_test;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          por_ok = 1'b0, en_ok = 1'b0;
   logic [NP-1:0] phase_pulled_low = '0, oc_flag = '0;
   logic          ov_flag = 1'b0, pg_above = 1'b0, ref_moving = 1'b0;
   logic          ss_top = 1'b0, ss_below90 = 1'b0, ss_below_lo = 1'b0;
   logic [2*NP-1:0] pwm_mode;
   logic          ss_charge, ss_discharge, ss_clamp, pgood;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vr_fault_seq #(.NPHASE(NP)) uut (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_ok(en_ok),
      .phase_pulled_low(phase_pulled_low), .oc_flag(oc_flag), .ov_flag(ov_flag),
      .pg_above(pg_above), .ref_moving(ref_moving), .ss_top(ss_top),
      .ss_below90(ss_below90), .ss_below_lo(ss_below_lo), .pwm_mode(pwm_mode),
      .ss_charge(ss_charge), .ss_discharge(ss_discharge), .ss_clamp(ss_clamp),
      .pgood(pgood));

   // {fitted strobes, expected pwm_mode during soft-start}
   localparam logic [8:0] DET_TAB [4] = '{
      {3'b111, 6'b010101},
      {3'b011, 6'b100101},
      {3'b101, 6'b011001},
      {3'b001, 6'b101001}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic outs(input string req, input logic [5:0] m, input logic ch,
                       input logic dis, input logic clp, input logic pg);
      chk(req, {26'd0, pwm_mode}, {26'd0, m});
      chk(req, {28'd0, ss_charge, ss_discharge, ss_clamp, pgood}, {28'd0, ch, dis, clp, pg});
   endtask

   task automatic power_up(input logic [2:0] fitted);
      por_ok = 1'b0; en_ok = 1'b0;
      ss_top = 1'b0; ss_below90 = 1'b0; ss_below_lo = 1'b0; pg_above = 1'b0;
      step(5);
      phase_pulled_low = fitted;
      por_ok = 1'b1; en_ok = 1'b1;
      step(6);
   endtask

   task automatic oc_event();
      oc_flag = 3'b001; step(3);
      oc_flag = '0; ss_top = 1'b0; pg_above = 1'b0;
      step(5);
   endtask

   task automatic finish_hiccup(input string req);
      ss_below90 = 1'b1; step(5);
      outs(req, 6'b101010, 1'b0, 1'b1, 1'b0, 1'b0);
      ss_below_lo = 1'b1; step(5);
      outs(req, 6'b010101, 1'b1, 1'b0, 1'b1, 1'b0);
      ss_below90 = 1'b0; ss_below_lo = 1'b0; ss_top = 1'b1; pg_above = 1'b1;
      step(5);
      outs(req, 6'b010101, 1'b1, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      step(3);
      outs("R1 reset", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      por_ok = 1'b1; phase_pulled_low = 3'b111; step(6);
      outs("R1 enable low", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2 / R3 detection table
      for (int k = 0; k < 4; k++) begin
         power_up(DET_TAB[k][8:6]);
         phase_pulled_low = ~DET_TAB[k][8:6]; // strobes after power-up are ignored
         step(5);
         outs("R2 R3 detect", DET_TAB[k][5:0], 1'b1, 1'b0, 1'b1, 1'b0);
      end

      power_up(3'b111);
      ss_top = 1'b1; step(5);
      outs("R3 ramp done", 6'b010101, 1'b1, 1'b0, 1'b0, 1'b0);
      pg_above = 1'b1; step(5);
      chk("R9 pgood rise", {31'd0, pgood}, 32'd1);
      ref_moving = 1'b1; pg_above = 1'b0; step(5);
      chk("R9 ref moving hold", {31'd0, pgood}, 32'd1);
      ref_moving = 1'b0; step(5);
      chk("R9 pgood fall", {31'd0, pgood}, 32'd0);
      pg_above = 1'b1; step(5);
      chk("R9 pgood again", {31'd0, pgood}, 32'd1);

      oc_flag = 3'b010; step(1); oc_flag = '0; step(5);
      outs("R4 pulse ignored", 6'b010101, 1'b1, 1'b0, 1'b0, 1'b1);

      oc_event();
      outs("R5 R10 hiccup off", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);
      step(5);
      chk("R5 no discharge above 90", {31'd0, ss_discharge}, 32'd0);
      finish_hiccup("R5 retry 1");

      oc_event();
      finish_hiccup("R5 retry 2");

      oc_event();
      outs("R6 lockout", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);
      ss_below90 = 1'b1; ss_below_lo = 1'b1; step(8);
      outs("R6 lockout holds", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);

      power_up(3'b111);
      outs("R6 released", 6'b010101, 1'b1, 1'b0, 1'b1, 1'b0);
      oc_event();
      outs("R6 count cleared", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);
      ss_below90 = 1'b1; step(5);
      chk("R6 count cleared discharge", {31'd0, ss_discharge}, 32'd1);

      power_up(3'b011);
      ss_top = 1'b1; pg_above = 1'b1; step(5);
      outs("R2 two phase run", 6'b100101, 1'b1, 1'b0, 1'b0, 1'b1);
      ov_flag = 1'b1; step(1); ov_flag = 1'b0; step(5);
      outs("R8 R10 overvoltage", 6'b100000, 1'b0, 1'b0, 1'b0, 1'b0);
      oc_flag = 3'b001; step(10); oc_flag = '0;
      outs("R8 latched", 6'b100000, 1'b0, 1'b0, 1'b0, 1'b0);
      en_ok = 1'b0; step(5);
      outs("R1 enable lost", 6'b101010, 1'b0, 1'b0, 1'b0, 1'b0);
      en_ok = 1'b1; ss_top = 1'b0; step(6);
      outs("R1 R8 restart", 6'b100101, 1'b1, 1'b0, 1'b1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule